// File: doc/BRIEF.md
# E1 Clock and Frame Pulse Divider

This block turns a stream of enable ticks into the E1 backplane clock family and its 8 kHz framing pulses. Each tick marks one half period of the fastest output clock, so ticks arrive at a rate equivalent to 65.536 MHz. One free-running position counter spans the 125 µs frame in 8192 ticks. Every output is decoded from that count and registered, so all of them share a single frame boundary at count zero.

The five clocks run at 32.768, 16.384, 8.192, 4.096 and 2.048 MHz, each with 50% duty. Each clock has an active-low frame pulse that is one of its own periods wide and centred on the boundary. A receive sync pulse covers the 2.048 MHz period just before the boundary, and a transmit sync pulse covers the period just after it.

An auxiliary output carries either the 2.048 MHz clock or an external 1.544 MHz clock. A two-bit reference-frequency select code makes the choice. The asynchronous reset is released through a two-stage synchronizer.

Top module: `e1_clk_frame_div`

## Requirements
- R1: `clk_o[0]` (32.768 MHz) inverts on every accepted tick. In any cycle without an accepted tick, all clocks, frame pulses and sync pulses keep their values.
- R2: Let p be the frame position in ticks, 0..8191. Clock index k (0 = 32.768 MHz, up to 4 = 2.048 MHz) is high exactly when bit k of p is 0. Its period is therefore 2^(k+1) ticks at 50% duty, and all clocks rise together at p = 0.
- R3: The position advances by one per accepted tick and wraps from 8191 to 0. Position 0 is the frame boundary.
- R4: Frame pulse `fp_n_o[k]` is low (active) when p < 2^k or p >= 8192 - 2^k, and high otherwise. It is therefore one period of clock k wide and centred on the boundary.
- R5: `rsp_n_o` is low exactly for p in 8160..8191, the final 2.048 MHz period of the frame.
- R6: `tsp_n_o` is low exactly for p in 0..31, the first 2.048 MHz period of the frame. It never overlaps `rsp_n_o`.
- R7: `aux_clk_o` equals `t1_clk_i` when `ref_sel_i` is 2'b10. For 2'b00, 2'b01 and 2'b11 it equals `clk_o[4]` (2.048 MHz).
- R8: While reset is active the position is 8191: all clocks are low, all frame pulses are low, `rsp_n_o` is low and `tsp_n_o` is high. The first accepted tick after reset lands on the frame boundary, p = 0.
- R9: Reset release is synchronized over two clock edges. Ticks at the first two rising edges after `rst_ni` goes high are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Half-period tick of the fastest output clock |
| ref_sel_i | input | 2 | Reference-frequency select code for the auxiliary output |
| t1_clk_i | input | 1 | External 1.544 MHz clock, in the system clock domain |
| clk_o | output | 5 | Divided clocks, index 0 = 32.768 MHz up to index 4 = 2.048 MHz |
| fp_n_o | output | 5 | Active-low frame pulses, one per clock index |
| rsp_n_o | output | 1 | Active-low receive sync pulse before the frame boundary |
| tsp_n_o | output | 1 | Active-low transmit sync pulse after the frame boundary |
| aux_clk_o | output | 1 | Auxiliary clock, 2.048 MHz or external 1.544 MHz |

## Verification
Every output is compared against an arithmetic model of the frame position in every cycle, while the tick pattern changes in several ways:
- An unbroken tick stream covers more than two full frames, so both wraps and every window edge are seen.
- A one-in-three tick pattern and a pseudo-random pattern separate the correct "hold without a tick" behaviour from a counter that advances on the system clock alone.
- A reset applied in the middle of a frame shows that the restart position and the two ignored ticks after release are honoured.
- The select code rotates through all four values while the external clock toggles, which tells the 2.048 MHz routing apart from the 1.544 MHz routing.

// File: rtl/e1_div_pkg.sv
package e1_div_pkg;
  typedef int unsigned u32_t;

  // Select code that routes the external 1.544 MHz clock to the auxiliary output
  localparam logic [1:0] SEL_T1 = 2'b10;

  // Clock k is high in the first half of each of its periods
  function automatic logic div_clk(u32_t pos, u32_t k);
    return ((pos >> k) & 32'd1) == 32'd0;
  endfunction

  // Active-low pulse, one period of clock k wide, centred on position 0
  function automatic logic frame_n(u32_t pos, u32_t k, u32_t frame);
    u32_t half;
    half = 32'd1 << k;
    return !((pos < half) || (pos >= frame - half));
  endfunction

  // Active-low pulse over the last sync period before the boundary
  function automatic logic rx_sync_n(u32_t pos, u32_t per, u32_t frame);
    return !(pos >= frame - per);
  endfunction

  // Active-low pulse over the first sync period after the boundary
  function automatic logic tx_sync_n(u32_t pos, u32_t per);
    return !(pos < per);
  endfunction
endpackage

// File: rtl/e1_rst_sync.sv
module e1_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_no = out_q;
endmodule

// File: rtl/e1_tick_counter.sv
module e1_tick_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] pos_nxt_o
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;

  // Next state: advance on a tick; the power-of-two frame wraps naturally
  always_comb begin
    pos_d = pos_q;
    if (tick_i) pos_d = pos_q + 1'b1;
  end

  // Reset to the last position so the first tick lands on the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '1;
    else if (tick_i) pos_q <= pos_d;
  end

  assign pos_nxt_o = pos_d;
endmodule

// File: rtl/e1_phase_decode.sv
module e1_phase_decode
  import e1_div_pkg::*;
#(
  parameter int unsigned CNT_W    = 13,
  parameter int unsigned NUM_CLK  = 5,
  parameter int unsigned SYNC_IDX = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   pos_nxt_i,
  output logic [NUM_CLK-1:0] clk_o,
  output logic [NUM_CLK-1:0] fp_n_o,
  output logic               rsp_n_o,
  output logic               tsp_n_o
);
  localparam u32_t FRAME    = 32'd1 << CNT_W;
  localparam u32_t SYNC_PER = 32'd1 << (SYNC_IDX + 1);

  logic [NUM_CLK-1:0] clk_d, clk_q;
  logic [NUM_CLK-1:0] fp_d, fp_q;
  logic               rsp_d, rsp_q;
  logic               tsp_d, tsp_q;
  u32_t               pos;

  assign pos = u32_t'(pos_nxt_i);

  // Next-state decode of every output from the upcoming position
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_dom
    assign clk_d[g] = div_clk(pos, u32_t'(g));
    assign fp_d[g]  = frame_n(pos, u32_t'(g), FRAME);
  end

  assign rsp_d = rx_sync_n(pos, SYNC_PER, FRAME);
  assign tsp_d = tx_sync_n(pos, SYNC_PER);

  // Reset values equal the decode of the all-ones position:
  // clocks low, frame pulses active, receive sync active, transmit sync idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '0;
      fp_q  <= '0;
      rsp_q <= 1'b0;
      tsp_q <= 1'b1;
    end else if (tick_i) begin
      clk_q <= clk_d;
      fp_q  <= fp_d;
      rsp_q <= rsp_d;
      tsp_q <= tsp_d;
    end
  end

  assign clk_o   = clk_q;
  assign fp_n_o  = fp_q;
  assign rsp_n_o = rsp_q;
  assign tsp_n_o = tsp_q;
endmodule

// File: rtl/e1_aux_select.sv
module e1_aux_select
  import e1_div_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       e1_clk_i,
  input  logic       t1_clk_i,
  output logic       aux_o
);
  always_comb begin
    aux_o = e1_clk_i;
    if (sel_i == SEL_T1) aux_o = t1_clk_i;
  end
endmodule

// File: rtl/e1_clk_frame_div.sv
module e1_clk_frame_div #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned NUM_CLK = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [1:0]         ref_sel_i,
  input  logic               t1_clk_i,
  output logic [NUM_CLK-1:0] clk_o,
  output logic [NUM_CLK-1:0] fp_n_o,
  output logic               rsp_n_o,
  output logic               tsp_n_o,
  output logic               aux_clk_o
);
  localparam int unsigned SYNC_IDX = NUM_CLK - 1;

  logic             rst_sync_n;
  logic [CNT_W-1:0] pos_nxt;
  logic [NUM_CLK-1:0] clk_int;

  e1_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_sync_n)
  );

  e1_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .pos_nxt_o (pos_nxt)
  );

  e1_phase_decode #(
    .CNT_W    (CNT_W),
    .NUM_CLK  (NUM_CLK),
    .SYNC_IDX (SYNC_IDX)
  ) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .pos_nxt_i (pos_nxt),
    .clk_o     (clk_int),
    .fp_n_o    (fp_n_o),
    .rsp_n_o   (rsp_n_o),
    .tsp_n_o   (tsp_n_o)
  );

  e1_aux_select u_aux (
    .sel_i    (ref_sel_i),
    .e1_clk_i (clk_int[SYNC_IDX]),
    .t1_clk_i (t1_clk_i),
    .aux_o    (aux_clk_o)
  );

  assign clk_o = clk_int;
endmodule

// File: rtl/e1_div_chk.sv
module e1_div_chk #(
  parameter int unsigned NUM_CLK = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [1:0]         ref_sel,
  input logic               t1_clk,
  input logic [NUM_CLK-1:0] clk_o,
  input logic [NUM_CLK-1:0] fp_n,
  input logic               rsp_n,
  input logic               tsp_n,
  input logic               aux
);
  p_fast_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> clk_o[0] != $past(clk_o[0]));

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(clk_o) && $stable(fp_n) && $stable(rsp_n) && $stable(tsp_n));

  for (genvar k = 1; k < NUM_CLK; k++) begin : g_align
    p_edge_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_o[k]) |-> $rose(clk_o[k-1]));
  end

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_fp
    p_fp_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fp_n[k]) |-> $fell(clk_o[k]));
  end

  // Receive and transmit sync windows never overlap (R5, R6)
  p_sync_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_n || tsp_n);

  p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tsp_n) |-> $rose(rsp_n) && $rose(clk_o[NUM_CLK-1]));

  p_aux_t1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == 2'b10) |-> aux == t1_clk);

  p_aux_e1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != 2'b10) |-> aux == clk_o[NUM_CLK-1]);
endmodule

bind e1_clk_frame_div e1_div_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_sync_n),
  .tick    (tick_i),
  .ref_sel (ref_sel_i),
  .t1_clk  (t1_clk_i),
  .clk_o   (clk_o),
  .fp_n    (fp_n_o),
  .rsp_n   (rsp_n_o),
  .tsp_n   (tsp_n_o),
  .aux     (aux_clk_o)
);

// File: tb/sim_e1_clk_frame_div.sv
`timescale 1ns/1ps
module sim_e1_clk_frame_div;
  localparam int NCLK  = 5;
  localparam int FRAME = 8192;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            tick;
  logic [1:0]      ref_sel;
  logic            t1_clk;
  logic [NCLK-1:0] clk_o;
  logic [NCLK-1:0] fp_n;
  logic            rsp_n;
  logic            tsp_n;
  logic            aux;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  int  pos    = FRAME - 1;
  int  ign    = 0;
  int  stepno = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  e1_clk_frame_div u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .ref_sel_i (ref_sel),
    .t1_clk_i  (t1_clk),
    .clk_o     (clk_o),
    .fp_n_o    (fp_n),
    .rsp_n_o   (rsp_n),
    .tsp_n_o   (tsp_n),
    .aux_clk_o (aux)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at pos %0d: got %b expected %b", tag, what, pos, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NCLK; k++) begin
      int half;
      half = 1 << k;
      chk((k == 0) ? "R1" : "R2", $sformatf("clk_o[%0d]", k), clk_o[k], ((pos >> k) & 1) == 0);
      chk("R4", $sformatf("fp_n[%0d]", k), fp_n[k], !((pos < half) || (pos >= FRAME - half)));
    end
    chk("R5", "rsp_n", rsp_n, !(pos >= FRAME - 32));
    chk("R6", "tsp_n", tsp_n, !(pos < 32));
    chk("R7", "aux", aux, (ref_sel == 2'b10) ? t1_clk : (((pos >> 4) & 1) == 0));
  endtask

  // Called just after a falling edge: check, drive, advance the model
  task automatic step(input bit t);
    check_all();
    tick    = t;
    stepno++;
    ref_sel = 2'((stepno / 7) % 4);
    t1_clk  = ~t1_clk;
    @(posedge clk);
    if (t && ign == 0) pos = (pos + 1) % FRAME;   // R3 position advance
    if (ign > 0) ign--;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick  = 1'b1;
    repeat (3) @(negedge clk);
    pos = FRAME - 1;
    chk("R8", "reset clocks low", (clk_o == '0), 1'b1);
    chk("R8", "reset frame pulses low", (fp_n == '0), 1'b1);
    chk("R8", "reset rsp_n", rsp_n, 1'b0);
    chk("R8", "reset tsp_n", tsp_n, 1'b1);
    rst_n = 1'b1;
    ign   = 2;
    step(1'b1);
    step(1'b1);
    // R9: two ticks after release are not accepted; still at last position
    chk("R9", "clk_o[0] after ignored ticks", clk_o[0], 1'b0);
    chk("R9", "tsp_n after ignored ticks", tsp_n, 1'b1);
    step(1'b1);
    // R8: first accepted tick lands on the frame boundary
    chk("R8", "boundary tsp_n", tsp_n, 1'b0);
    chk("R8", "boundary clocks high", (clk_o == '1), 1'b1);
  endtask

  initial begin
    logic [15:0] lf;
    rst_n   = 1'b0;
    tick    = 1'b0;
    ref_sel = 2'b00;
    t1_clk  = 1'b0;
    do_reset();
    // Continuous ticks over more than two frames (R1-style sweep of all positions)
    for (int i = 0; i < 2 * FRAME + 100; i++) step(1'b1);
    // Sparse ticks: one in three (hold behaviour, R1)
    for (int i = 0; i < 3000; i++) step(i % 3 == 0);
    // Pseudo-random tick gaps
    lf = 16'hACE1;
    for (int i = 0; i < 12000; i++) begin
      step(lf[0]);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    // Reset in mid-frame, then run across a wrap again
    do_reset();
    for (int i = 0; i < FRAME + 50; i++) step(1'b1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule